// File: doc/BRIEF.md
# Indirect PHY Configuration Register Bridge

This block lets software reach a bank of internal PHY configuration registers through a six-word window of memory-mapped registers. Software first loads the write data and turns on the lane gate. It then writes a command word that holds the PHY register address, a write or read command bit and a register-group bit. The bridge then holds a request on a narrow PHY-side register bus until the PHY answers with a one-cycle response. On a read it captures the PHY's read data. It then raises an acknowledge flag that software polls. Software polls for a bounded number of reads and counts a missing acknowledge as a timeout.

Each command runs until software writes zero to the command word. That write puts the bridge back in idle and clears the acknowledge, and only then does the bridge accept the next command. The window also drives two PHY reset outputs, a full PHY reset and a soft reset. Software applies them, holds them for a short interval and releases them by writing zero.

Top module: `pcb_bridge`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge) every window word reads 0, and phy_req, phy_rst and phy_srst are low.
- R2: Software addresses the window by word index, with byte offset = 4 × index: 0 = command, 1 = write data, 2 = lane gate (bit 0), 3 = resets (bit 1 PHY reset, bit 0 soft reset), 4 = captured read data, 5 = acknowledge (bit 0). The command, write-data, lane and reset words read back what was written. Reads of indices 6 and 7 return 0.
- R3: Command word fields are: bits 7:0 the PHY register address, bit 8 the write command, bit 9 the read command, bit 10 the group select. A command written from idle, with exactly one command bit set and the lane gate on, raises phy_req on the next cycle. phy_req then carries phy_we = bit 8 and phy_wdata = the write-data word.
- R4: On the cycle that phy_ack answers a read request, the bridge loads phy_rdata into the read-data word. From the next cycle the acknowledge bit reads 1, and the captured data reads back no later than that.
- R5: phy_addr is the group bit (command bit 10) above the 8-bit register address, so the two groups reach different PHY registers.
- R6: The acknowledge bit stays 1 until a write of zero to command bits 10:0. That write clears it and returns the bridge to idle on the next cycle. The same zero write also abandons a request that the PHY has not yet answered.
- R7: While a command is pending or acknowledged, nonzero command writes and write-data writes are ignored. The stored command, the write data, the PHY bus and the acknowledge bit are all unchanged.
- R8: A command with both bit 8 and bit 9 set issues no PHY request and leaves the acknowledge bit at 0.
- R9: With lane gate bit 0 at 0, a command issues no PHY request and no acknowledge.
- R10: phy_rst and phy_srst follow reset-word bits 1 and 0. While bit 1 is 1, no request is issued and the acknowledge bit stays 0. Setting bit 1 during a pending request drops that request on the next cycle.
- R11: phy_req stays high, with phy_addr and phy_wdata stable, until the cycle phy_ack is seen. It is low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Window write strobe |
| reg_word | input | 3 | Window word index |
| reg_wdata | input | DATA_W | Window write data |
| reg_rdata | output | DATA_W | Window read data for reg_word (combinational) |
| phy_req | output | 1 | PHY register access request |
| phy_we | output | 1 | 1 = write access, 0 = read access |
| phy_addr | output | PHY_AW+1 | Group bit and PHY register address |
| phy_wdata | output | DATA_W | Data for a PHY write |
| phy_ack | input | 1 | One-cycle PHY response |
| phy_rdata | input | DATA_W | PHY read data, valid with phy_ack |
| phy_rst | output | 1 | PHY reset |
| phy_srst | output | 1 | PHY soft reset |

## Verification
A window write changes its word, the reset pins and the FSM state at the next clock edge. The next cycle phy_req rises, and the PHY model answers after a chosen number of cycles. The read data and the acknowledge bit appear one edge after the response cycle, and phy_req falls on that same edge. A behavioural model in the bench updates on each rising edge from the same inputs. The DUT outputs are compared with it on each falling edge, once every register on the path has settled. Directed polls then count reads until the acknowledge appears, or confirm that it never does.

// File: rtl/pcb_pkg.sv
// Package for the PHY configuration bridge.
// Holds the window word indices and the command state type.
// Assumes a word-indexed window of eight slots, six of them used.
package pcb_pkg;
    localparam logic [2:0] W_CMD   = 3'd0;
    localparam logic [2:0] W_WDATA = 3'd1;
    localparam logic [2:0] W_LANE  = 3'd2;
    localparam logic [2:0] W_RST   = 3'd3;
    localparam logic [2:0] W_RDATA = 3'd4;
    localparam logic [2:0] W_ACK   = 3'd5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DONE = 2'd2
    } pcb_state_e;
endpackage

// File: rtl/pcb_window.sv
// Software window of the PHY configuration bridge.
// Holds the command, write-data, lane, reset and read-capture words, and
// muxes one of them onto the read bus. Assumes the FSM reports when it is
// idle and strobes cap_en on the response cycle of a read.
module pcb_window
    import pcb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PHY_AW = 8,
    localparam int CMD_W = PHY_AW + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_word,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fsm_idle,
    input  logic              ack_flag,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              lane_on,
    output logic [1:0]        rst_bits,
    output logic              cmd_wr,
    output logic              cmd_zero,
    output logic              phy_block
);
    logic [DATA_W-1:0] rdcap_q;

    // Decode the command write and the idle-return (zero) pattern.
    always_comb begin
        cmd_wr   = reg_we && (reg_word == W_CMD);
        cmd_zero = (reg_wdata[CMD_W-1:0] == '0);
    end

    // The PHY is blocked by a held reset or by a reset write landing now.
    always_comb begin
        phy_block = rst_bits[1] || (reg_we && (reg_word == W_RST) && reg_wdata[1]);
    end

    // Command word: taken from idle, or a zero write at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (cmd_wr && (fsm_idle || cmd_zero))
            cmd_q <= reg_wdata[CMD_W-1:0];
    end

    // Write-data word: frozen while a command is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdata_q <= '0;
        else if (reg_we && (reg_word == W_WDATA) && fsm_idle)
            wdata_q <= reg_wdata;
    end

    // Lane gate and reset bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_on  <= 1'b0;
            rst_bits <= 2'b00;
        end else if (reg_we) begin
            if (reg_word == W_LANE)
                lane_on <= reg_wdata[0];
            if (reg_word == W_RST)
                rst_bits <= reg_wdata[1:0];
        end
    end

    // Read capture on the PHY response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdcap_q <= '0;
        else if (cap_en)
            rdcap_q <= phy_rdata;
    end

    // Read-back mux.
    always_comb begin
        unique case (reg_word)
            W_CMD:   reg_rdata = DATA_W'(cmd_q);
            W_WDATA: reg_rdata = wdata_q;
            W_LANE:  reg_rdata = DATA_W'(lane_on);
            W_RST:   reg_rdata = DATA_W'(rst_bits);
            W_RDATA: reg_rdata = rdcap_q;
            W_ACK:   reg_rdata = DATA_W'(ack_flag);
            default: reg_rdata = '0;
        endcase
    end

    AST_WD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!fsm_idle && reg_we && (reg_word == W_WDATA)) |=> $stable(wdata_q)); // R7
endmodule

// File: rtl/pcb_cmd_fsm.sv
// Command sequencer of the PHY configuration bridge.
// Launches one PHY access per valid command from idle, waits for the
// one-cycle response, then holds "done" until software writes zero.
// Assumes the PHY answers a held request with exactly one phy_ack pulse.
module pcb_cmd_fsm
    import pcb_pkg::*;
#(
    parameter int PHY_AW = 8,
    localparam int CMD_W  = PHY_AW + 3,
    localparam int WR_BIT = PHY_AW,
    localparam int RD_BIT = PHY_AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic             cmd_zero,
    input  logic [CMD_W-1:0] cmd_new,
    input  logic             cmd_is_rd,
    input  logic             lane_on,
    input  logic             hold,
    input  logic             phy_ack,
    output pcb_state_e       state_q,
    output logic             cap_en
);
    pcb_state_e state_d;
    logic       launch_ok;

    // A launch needs exactly one command bit and the lane gate on.
    always_comb begin
        launch_ok = cmd_wr && lane_on && (cmd_new[WR_BIT] ^ cmd_new[RD_BIT]);
    end

    // Next-state logic; a held PHY reset overrides everything.
    always_comb begin
        state_d = state_q;
        if (hold) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (launch_ok) state_d = ST_REQ;
                ST_REQ:  if (cmd_wr && cmd_zero) state_d = ST_IDLE;
                         else if (phy_ack)       state_d = ST_DONE;
                ST_DONE: if (cmd_wr && cmd_zero) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Capture strobe: a read request answered and not being cancelled.
    always_comb begin
        cap_en = (state_q == ST_REQ) && (state_d == ST_DONE) && cmd_is_rd;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    AST_ACK_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == ST_DONE) |-> $past(phy_ack)); // R4
    AST_BOTH_BITS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_wr && cmd_new[WR_BIT] && cmd_new[RD_BIT]) |=> (state_q == ST_IDLE)); // R8
    AST_LANE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && cmd_wr && !lane_on) |=> (state_q == ST_IDLE)); // R9
endmodule

// File: rtl/pcb_bridge.sv
// PHY configuration bridge top.
// Joins the software window to the command sequencer and drives the
// narrow PHY register bus and the two PHY reset outputs.
// Assumes DATA_W >= PHY_AW + 3 so the command word fits one window word.
module pcb_bridge
    import pcb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PHY_AW = 8,
    localparam int CMD_W   = PHY_AW + 3,
    localparam int WR_BIT  = PHY_AW,
    localparam int RD_BIT  = PHY_AW + 1,
    localparam int GRP_BIT = PHY_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_word,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              phy_req,
    output logic              phy_we,
    output logic [PHY_AW:0]   phy_addr,
    output logic [DATA_W-1:0] phy_wdata,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_rdata,
    output logic              phy_rst,
    output logic              phy_srst
);
    pcb_state_e        state_q;
    logic [CMD_W-1:0]  cmd_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        rst_bits;
    logic              lane_on, cmd_wr, cmd_zero, phy_block, cap_en;
    logic              fsm_idle, ack_flag;

    // State flags shared by the window.
    always_comb begin
        fsm_idle = (state_q == ST_IDLE);
        ack_flag = (state_q == ST_DONE);
    end

    pcb_window #(.DATA_W(DATA_W), .PHY_AW(PHY_AW)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_word  (reg_word),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fsm_idle  (fsm_idle),
        .ack_flag  (ack_flag),
        .cap_en    (cap_en),
        .phy_rdata (phy_rdata),
        .cmd_q     (cmd_q),
        .wdata_q   (wdata_q),
        .lane_on   (lane_on),
        .rst_bits  (rst_bits),
        .cmd_wr    (cmd_wr),
        .cmd_zero  (cmd_zero),
        .phy_block (phy_block)
    );

    pcb_cmd_fsm #(.PHY_AW(PHY_AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .cmd_zero  (cmd_zero),
        .cmd_new   (reg_wdata[CMD_W-1:0]),
        .cmd_is_rd (cmd_q[RD_BIT]),
        .lane_on   (lane_on),
        .hold      (phy_block),
        .phy_ack   (phy_ack),
        .state_q   (state_q),
        .cap_en    (cap_en)
    );

    // PHY-side bus, driven from the stored command and write data.
    always_comb begin
        phy_req   = (state_q == ST_REQ);
        phy_we    = cmd_q[WR_BIT];
        phy_addr  = {cmd_q[GRP_BIT], cmd_q[PHY_AW-1:0]};
        phy_wdata = wdata_q;
        phy_rst   = rst_bits[1];
        phy_srst  = rst_bits[0];
    end

    AST_RST_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rst |-> (!phy_req && !ack_flag)); // R10
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack && !phy_block && !(cmd_wr && cmd_zero))
        |=> (phy_req && $stable(phy_addr) && $stable(phy_wdata))); // R11
    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_ack) |=> !phy_req); // R11
endmodule

// File: tb/pcb_bridge_bench.sv
`timescale 1ns/1ps
module pcb_bridge_bench;
    localparam int DW = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_word = 3'd0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          phy_req, phy_we, phy_rst, phy_srst;
    logic [AW:0]   phy_addr;
    logic [DW-1:0] phy_wdata;
    logic          phy_ack = 1'b0;
    logic [DW-1:0] phy_rdata = '0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int lat = 2;
    int req_cycles = 0;
    bit started = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pcb_bridge u_pcb_bridge (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_word(reg_word),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .phy_req(phy_req),
        .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata), .phy_rst(phy_rst),
        .phy_srst(phy_srst)
    );

    // ---------------- PHY model: register array, variable delay ----------
    logic [DW-1:0] mem [0:511];
    int  pcnt = 0;
    bit  served = 0;
    initial for (int i = 0; i < 512; i++) mem[i] = 32'h0A000000 + i;

    always @(negedge clk) begin
        phy_ack = 1'b0;
        if (!rst_n || !phy_req) begin
            pcnt = 0;
            served = 0;
        end else if (!served) begin
            if (pcnt >= lat) begin
                phy_ack = 1'b1;
                phy_rdata = mem[phy_addr];
                if (phy_we) mem[phy_addr] = phy_wdata;
                served = 1;
            end else begin
                pcnt++;
            end
        end
        if (phy_req) req_cycles++;
    end

    // ---------------- behavioural reference model -------------------------
    int m_state = 0;  // 0 idle, 1 waiting, 2 acknowledged
    logic [10:0]   m_cmd = '0;
    logic [DW-1:0] m_wd = '0, m_rd = '0;
    logic          m_lane = 0;
    logic [1:0]    m_rst = '0;

    always @(posedge clk) begin
        bit hold, cw, zero;
        int nxt;
        started = 1;
        cyc++;
        if (!rst_n) begin
            m_state = 0; m_cmd = '0; m_wd = '0; m_rd = '0; m_lane = 0; m_rst = '0;
        end else begin
            hold = m_rst[1] || (reg_we && reg_word == 3 && reg_wdata[1]);
            cw   = reg_we && reg_word == 0;
            zero = (reg_wdata[10:0] == 0);
            nxt  = m_state;
            if (hold) nxt = 0;
            else if (m_state == 0) begin
                if (cw && m_lane && (reg_wdata[8] != reg_wdata[9])) nxt = 1;
            end else if (cw && zero) nxt = 0;
            else if (m_state == 1 && phy_ack) nxt = 2;
            if (m_state == 1 && nxt == 2 && m_cmd[9]) m_rd = phy_rdata;
            if (cw && (m_state == 0 || zero)) m_cmd = reg_wdata[10:0];
            if (reg_we && reg_word == 1 && m_state == 0) m_wd = reg_wdata;
            if (reg_we && reg_word == 2) m_lane = reg_wdata[0];
            if (reg_we && reg_word == 3) m_rst = reg_wdata[1:0];
            m_state = nxt;
        end
    end

    function automatic logic [DW-1:0] m_read(input logic [2:0] w);
        case (w)
            3'd0: return {21'b0, m_cmd};
            3'd1: return m_wd;
            3'd2: return {31'b0, m_lane};
            3'd3: return {30'b0, m_rst};
            3'd4: return m_rd;
            3'd5: return {31'b0, m_state == 2};
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of every output with the model.
    always @(negedge clk) begin
        if (started && !finished) begin
            check("R11 phy_req", {31'b0, phy_req}, {31'b0, m_state == 1});
            check("R3 phy_we", {31'b0, phy_we}, {31'b0, m_cmd[8]});
            check("R5 phy_addr", {23'b0, phy_addr}, {23'b0, m_cmd[10], m_cmd[7:0]});
            check("R3 phy_wdata", phy_wdata, m_wd);
            check("R10 phy_rst", {30'b0, phy_rst, phy_srst}, {30'b0, m_rst});
            check("R2 reg_rdata", reg_rdata, m_read(reg_word));
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 60000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=60000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus tasks (start at negedge+1) -----------------
    task automatic wr(input logic [2:0] w, input logic [DW-1:0] v);
        reg_we = 1; reg_word = w; reg_wdata = v;
        @(negedge clk); #1;
        reg_we = 0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] w, output logic [DW-1:0] v);
        reg_word = w;
        @(negedge clk);
        v = reg_rdata;
        #1;
    endtask

    task automatic poll(input int maxn, output bit got);
        logic [DW-1:0] v;
        got = 0;
        for (int i = 0; i < maxn && !got; i++) begin
            rd(3'd5, v);
            if (v[0]) got = 1;
        end
    endtask

    initial begin
        logic [DW-1:0] v;
        bit got;
        int rc;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        // R1: reset state
        for (int w = 0; w < 6; w++) begin
            rd(w[2:0], v); check("R1 reset word", v, '0);
        end
        check("R1 phy_req low", {31'b0, phy_req}, '0);
        // R2: readback and unused words
        wr(3'd1, 32'hDEADBEEF); rd(3'd1, v); check("R2 wdata readback", v, 32'hDEADBEEF);
        wr(3'd2, 32'h1); rd(3'd2, v); check("R2 lane readback", v, 32'h1);
        rd(3'd6, v); check("R2 unused word", v, '0);
        // R3: write to group 0, register 0x43
        lat = 3;
        wr(3'd0, 32'h143);
        check("R3 req one cycle after command", {31'b0, phy_req}, 32'h1);
        poll(100, got); check("R3 write acknowledged", {31'b0, got}, 32'h1);
        check("R3 PHY register written", mem[9'h043], 32'hDEADBEEF);
        check("R11 req low after ack", {31'b0, phy_req}, '0);
        wr(3'd0, 32'h0); rd(3'd5, v); check("R6 zero clears ack", v, '0);
        // R5: group 1, same address
        wr(3'd1, 32'h12345678); wr(3'd0, 32'h543);
        poll(100, got); check("R5 group write ack", {31'b0, got}, 32'h1);
        check("R5 group 1 register", mem[9'h143], 32'h12345678);
        check("R5 group 0 untouched", mem[9'h043], 32'hDEADBEEF);
        wr(3'd0, 32'h0);
        // R4: reads with two delays
        lat = 5;
        wr(3'd0, 32'h243); poll(100, got);
        check("R4 read ack", {31'b0, got}, 32'h1);
        rd(3'd4, v); check("R4 read data group 0", v, 32'hDEADBEEF);
        wr(3'd0, 32'h0);
        lat = 0;
        wr(3'd0, 32'h643); poll(100, got);
        rd(3'd4, v); check("R4 read data group 1", v, 32'h12345678);
        // R6: ack persists until zero write
        repeat (10) @(negedge clk); #1;
        rd(3'd5, v); check("R6 ack held", v, 32'h1);
        // R7: nonzero write while acknowledged
        wr(3'd0, 32'h1AA); rd(3'd0, v); check("R7 cmd kept while done", v, 32'h643);
        rd(3'd5, v); check("R7 ack kept", v, 32'h1);
        wr(3'd0, 32'h0);
        // R7: writes while waiting
        lat = 20;
        wr(3'd0, 32'h210);
        wr(3'd0, 32'h1AA); wr(3'd1, 32'h0);
        rd(3'd0, v); check("R7 cmd kept while busy", v, 32'h210);
        rd(3'd1, v); check("R7 wdata kept while busy", v, 32'h12345678);
        poll(100, got);
        rd(3'd4, v); check("R7 busy read result", v, 32'h0A000010);
        check("R7 no stray write", mem[9'h0AA], 32'h0A0000AA);
        wr(3'd0, 32'h0);
        // R6: zero write abandons an unanswered request
        wr(3'd0, 32'h211); wr(3'd0, 32'h0);
        check("R6 abandon drops req", {31'b0, phy_req}, '0);
        // R8: both bits
        lat = 1;
        rc = req_cycles;
        wr(3'd0, 32'h343); poll(30, got);
        check("R8 no ack", {31'b0, got}, '0);
        check("R8 no request", rc, req_cycles);
        wr(3'd0, 32'h0);
        // R9: lane off
        wr(3'd2, 32'h0); wr(3'd1, 32'h55AA55AA);
        rc = req_cycles;
        wr(3'd0, 32'h150); poll(30, got);
        check("R9 no ack", {31'b0, got}, '0);
        check("R9 no request", rc, req_cycles);
        check("R9 PHY unchanged", mem[9'h050], 32'h0A000050);
        wr(3'd0, 32'h0); wr(3'd2, 32'h1);
        // R10: reset blocks, and aborts a pending request
        wr(3'd3, 32'h2);
        check("R10 phy_rst pin", {31'b0, phy_rst}, 32'h1);
        rc = req_cycles;
        wr(3'd0, 32'h150); poll(20, got);
        check("R10 no ack in reset", {31'b0, got}, '0);
        check("R10 no request in reset", rc, req_cycles);
        wr(3'd0, 32'h0); wr(3'd3, 32'h0);
        lat = 40;
        wr(3'd0, 32'h151);
        repeat (4) @(negedge clk); #1;
        wr(3'd3, 32'h2);
        check("R10 request dropped", {31'b0, phy_req}, '0);
        repeat (50) @(negedge clk); #1;
        rd(3'd5, v); check("R10 ack low after abort", v, '0);
        check("R10 aborted write not applied", mem[9'h051], 32'h0A000051);
        wr(3'd3, 32'h1);
        check("R10 soft reset pin", {30'b0, phy_rst, phy_srst}, 32'h1);
        wr(3'd3, 32'h0); wr(3'd0, 32'h0);
        // R11: long wait keeps request until response
        lat = 12;
        wr(3'd0, 32'h160);
        repeat (8) @(negedge clk); #1;
        check("R11 req held while waiting", {31'b0, phy_req}, 32'h1);
        poll(100, got); check("R11 eventual ack", {31'b0, got}, 32'h1);
        wr(3'd0, 32'h0);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule